// File: doc/BRIEF.md
# Wake-up and Carriage-Return Autobaud Sequencer

This block sits between an asynchronous serial terminal line and a sleeping controller. While the link is idle it watches the receive line. The first start bit it sees raises a ring request toward the controller. The ring request ends when the controller answers by asserting its wake input, at which point the block drives modem-enable high. If the controller never answers, the ring request ends by itself after a fixed interval.

With modem-enable high, the block listens for carriage returns to learn the terminal's bit rate. It times the low period of a start bit in system clocks and snaps that time to the closest of four supported rates. It then decodes the next character at that rate. A carriage return locks the rate. Any other character makes the block measure again, and the listening deadline keeps running from where it was. After a lock, the block transmits a three-character greeting at the locked rate and then reports command mode until the controller releases its wake input. If no lock arrives before the listening deadline, the block hangs up.

All timer lengths are parameters in clock cycles, so a bench can run with shortened intervals. The receive line passes through a parameterised synchroniser before any decision is taken.

Top module: `wake_autobaud_seq`

## Requirements
- R1: In the idle state, with `rx_i` high after reset, a low level on `rx_i` drives `ring_o` high on the (SYNC_STAGES+1)-th rising clock edge after `rx_i` falls.
- R2: If `wake_i` stays low, `ring_o` stays high for exactly RING_CYC cycles and then returns low. The block is then idle again.
- R3: `wake_i` high while `ring_o` is high clears `ring_o` and sets `me_o` on the next clock edge. `ring_o` and `me_o` are never high together.
- R4: The measured start-bit low time picks the nearest rate, reported on `baud_sel_o` as 0 = 300, 1 = 1200, 2 = 9600 and 3 = 76800 baud. Each bit period is CLK_HZ / baud cycles, and the decision boundaries lie halfway between adjacent periods. `baud_sel_o` is 0 after reset.
- R5: While the block waits for a start bit to measure, a low pulse shorter than half of the 76800-baud period is discarded and does not set the rate.
- R6: The character after the measured one is received as 8N1 (LSB first) at the chosen rate. The value 0x0D with a valid stop bit locks the rate. Any other value restarts the measurement and does not restart the listening deadline.
- R7: After a lock, `tx_o` sends 0x0D, 0x0A and 0x2A in that order as 8N1, LSB first, at the locked rate. After the last stop bit, `cmd_mode_o` goes high with `me_o` still high.
- R8: If no lock occurs, `me_o` drops exactly TIMEOUT_CYC cycles after it rose. In that same cycle `hangup_o` pulses high for one cycle, and the block returns to idle.
- R9: In command mode, `wake_i` low clears `cmd_mode_o` and `me_o` on the next clock edge.
- R10: `tx_o` is high whenever no greeting is being sent, and always while `me_o` is low.
- R11: After reset, `ring_o`, `me_o`, `cmd_mode_o` and `hangup_o` are low, `tx_o` is high and `baud_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial data from the terminal, idle high |
| wake_i | input | 1 | Controller awake; answers a ring and holds command mode |
| ring_o | output | 1 | Ring request toward the controller |
| me_o | output | 1 | Modem-enable, high from wake until hang-up or release |
| cmd_mode_o | output | 1 | Rate locked and greeting sent |
| hangup_o | output | 1 | One-cycle pulse when the listening deadline expires |
| tx_o | output | 1 | Serial data toward the terminal, idle high |
| baud_sel_o | output | 2 | Index of the selected rate |

## Verification
The ring output is due SYNC_STAGES+1 edges after the start bit and falls exactly RING_CYC edges later. Modem-enable follows wake one edge later, and a hang-up lands exactly TIMEOUT_CYC edges after modem-enable rose. The bench counts clock edges from each stimulus and samples on the falling edge at precisely those counts, checking one cycle before each transition and at the transition itself. Greeting characters are decoded independently, at the centre of each bit at the nominal period. Command mode is checked one bit period after the last stop bit. Mutual exclusion of ring and modem-enable, and a quiet transmit line while modem-enable is low, are compared on every clock.

// File: rtl/wab_pkg.sv
package wab_pkg;

   localparam int NRATES = 4;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RING, ST_MWAIT, ST_MLOW, ST_SKIP, ST_CONF, ST_GREET, ST_CMD
   } wab_state_e;

   // rate index 0..3, slowest first
   function automatic int unsigned wab_baud(input int idx);
      case (idx)
         0:       return 300;
         1:       return 1200;
         2:       return 9600;
         default: return 76800;
      endcase
   endfunction

   function automatic int unsigned wab_period(input int unsigned clk_hz, input int idx);
      return clk_hz / wab_baud(idx);
   endfunction

   function automatic logic [7:0] wab_greet(input logic [1:0] idx);
      case (idx)
         2'd0:    return 8'h0D;
         2'd1:    return 8'h0A;
         default: return 8'h2A;
      endcase
   endfunction

endpackage

// File: rtl/wab_rate_pick.sv
module wab_rate_pick
   import wab_pkg::*;
#(
   parameter int unsigned CLK_HZ = 1228800,
   parameter int          PER_W  = 16
) (
   input  logic [PER_W-1:0] meas_i,
   output logic [1:0]       sel_o,
   output logic [PER_W-1:0] per_o
);

   logic [NRATES-2:0] below;
   logic [PER_W-1:0]  per_tab [NRATES];

   for (genvar i = 0; i < NRATES - 1; i++) begin : g_thr
      localparam int unsigned THR = (wab_period(CLK_HZ, i) + wab_period(CLK_HZ, i + 1)) / 2;
      assign below[i] = meas_i < PER_W'(THR);
   end

   for (genvar i = 0; i < NRATES; i++) begin : g_tab
      assign per_tab[i] = PER_W'(wab_period(CLK_HZ, i));
   end

   always_comb begin
      sel_o = '0;
      for (int i = 0; i < NRATES - 1; i++) begin
         if (below[i]) sel_o = sel_o + 2'd1;
      end
   end

   assign per_o = per_tab[sel_o];

endmodule

// File: rtl/wab_uart_rx.sv
module wab_uart_rx #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             rx_i,
   input  logic [PER_W-1:0] per_i,
   output logic             done_o,
   output logic [7:0]       data_o,
   output logic             stop_ok_o
);

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_ph_e;

   rx_ph_e           ph_q;
   logic [PER_W-1:0] cnt_q;
   logic [2:0]       bit_q;
   logic [7:0]       sh_q;
   logic [PER_W-1:0] half_last, full_last;

   assign half_last = (per_i >> 1) - 1'b1;
   assign full_last = per_i - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q      <= RX_IDLE;
         cnt_q     <= '0;
         bit_q     <= '0;
         sh_q      <= '0;
         done_o    <= 1'b0;
         stop_ok_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!en_i) begin
            ph_q <= RX_IDLE;
         end else begin
            unique case (ph_q)
               RX_IDLE: if (!rx_i) begin
                  ph_q  <= RX_START;
                  cnt_q <= '0;
               end
               RX_START: if (cnt_q == half_last) begin
                  ph_q  <= rx_i ? RX_IDLE : RX_DATA;
                  cnt_q <= '0;
                  bit_q <= '0;
               end else cnt_q <= cnt_q + 1'b1;
               RX_DATA: if (cnt_q == full_last) begin
                  sh_q  <= {rx_i, sh_q[7:1]};
                  cnt_q <= '0;
                  if (bit_q == 3'd7) ph_q <= RX_STOP;
                  else bit_q <= bit_q + 1'b1;
               end else cnt_q <= cnt_q + 1'b1;
               RX_STOP: if (cnt_q == full_last) begin
                  done_o    <= 1'b1;
                  stop_ok_o <= rx_i;
                  ph_q      <= RX_IDLE;
               end else cnt_q <= cnt_q + 1'b1;
               default: ph_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign data_o = sh_q;

endmodule

// File: rtl/wab_uart_tx.sv
module wab_uart_tx #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic [7:0]       byte_i,
   input  logic [PER_W-1:0] per_i,
   output logic             tx_o,
   output logic             done_o
);

   logic             busy_q;
   logic [9:0]       sh_q;
   logic [PER_W-1:0] cnt_q;
   logic [3:0]       nbit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sh_q   <= '1;
         cnt_q  <= '0;
         nbit_q <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!busy_q) begin
            if (go_i) begin
               busy_q <= 1'b1;
               sh_q   <= {1'b1, byte_i, 1'b0};
               cnt_q  <= '0;
               nbit_q <= '0;
            end
         end else if (cnt_q == per_i - 1'b1) begin
            cnt_q <= '0;
            sh_q  <= {1'b1, sh_q[9:1]};
            if (nbit_q == 4'd9) begin
               busy_q <= 1'b0;
               done_o <= 1'b1;
            end else nbit_q <= nbit_q + 1'b1;
         end else cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tx_o = busy_q ? sh_q[0] : 1'b1;

endmodule

// File: rtl/wake_autobaud_seq.sv
module wake_autobaud_seq
   import wab_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 1228800,
   parameter int unsigned RING_CYC    = CLK_HZ,
   parameter int unsigned TIMEOUT_CYC = 40 * CLK_HZ,
   parameter int          SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_i,
   input  logic       wake_i,
   output logic       ring_o,
   output logic       me_o,
   output logic       cmd_mode_o,
   output logic       hangup_o,
   output logic       tx_o,
   output logic [1:0] baud_sel_o
);

   localparam int unsigned PMAX    = wab_period(CLK_HZ, 0);
   localparam int unsigned PMIN    = wab_period(CLK_HZ, NRATES - 1);
   localparam int          PER_W   = $clog2(10 * PMAX + 1);
   localparam int unsigned TMAX    = (RING_CYC > TIMEOUT_CYC) ? RING_CYC : TIMEOUT_CYC;
   localparam int          TCNT_W  = $clog2(TMAX + 1);
   localparam int unsigned MIN_LOW = PMIN / 2;
   localparam logic [TCNT_W-1:0] RING_LAST = TCNT_W'(RING_CYC - 1);
   localparam logic [TCNT_W-1:0] TO_LAST   = TCNT_W'(TIMEOUT_CYC - 1);

   if (PMIN < 4) begin : g_bad_clk
      $error("CLK_HZ too low for the fastest rate");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (RING_CYC < 1 || TIMEOUT_CYC < 2) begin : g_bad_tmr
      $error("timer lengths out of range");
   end

   // receive-line synchroniser
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;
   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sync_q <= '1;
         else        sync_q <= rx_i;
   end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
   end
   assign rx_s = sync_q[SYNC_STAGES-1];

   wab_state_e        state_q;
   logic [TCNT_W-1:0] tcnt_q;
   logic [PER_W-1:0]  mcnt_q, per_q, pick_per, hold_last;
   logic [1:0]        sel_q, pick_sel, gi_q;
   logic              tx_go_q, hang_q;
   logic              rx_done, rx_stop_ok, tx_done;
   logic [7:0]        rx_byte;

   assign hold_last = (per_q << 3) + (per_q >> 1) - 1'b1;

   wab_rate_pick #(.CLK_HZ(CLK_HZ), .PER_W(PER_W)) u_pick (
      .meas_i(mcnt_q), .sel_o(pick_sel), .per_o(pick_per)
   );

   wab_uart_rx #(.PER_W(PER_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .en_i(state_q == ST_CONF), .rx_i(rx_s),
      .per_i(per_q), .done_o(rx_done), .data_o(rx_byte), .stop_ok_o(rx_stop_ok)
   );

   wab_uart_tx #(.PER_W(PER_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .go_i(tx_go_q), .byte_i(wab_greet(gi_q)),
      .per_i(per_q), .tx_o(tx_o), .done_o(tx_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tcnt_q  <= '0;
         mcnt_q  <= '0;
         per_q   <= PER_W'(PMAX);
         sel_q   <= '0;
         gi_q    <= '0;
         tx_go_q <= 1'b0;
         hang_q  <= 1'b0;
      end else begin
         tx_go_q <= 1'b0;
         hang_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (!rx_s) begin
               state_q <= ST_RING;
               tcnt_q  <= '0;
            end
            ST_RING: if (wake_i) begin
               state_q <= ST_MWAIT;
               tcnt_q  <= '0;
            end else if (tcnt_q == RING_LAST) state_q <= ST_IDLE;
            else tcnt_q <= tcnt_q + 1'b1;
            ST_GREET: if (tx_done) begin
               if (gi_q == 2'd2) state_q <= ST_CMD;
               else begin
                  gi_q    <= gi_q + 1'b1;
                  tx_go_q <= 1'b1;
               end
            end
            ST_CMD: if (!wake_i) state_q <= ST_IDLE;
            default: begin
               // listening states share one deadline
               if (tcnt_q == TO_LAST) begin
                  state_q <= ST_IDLE;
                  hang_q  <= 1'b1;
               end else begin
                  tcnt_q <= tcnt_q + 1'b1;
                  case (state_q)
                     ST_MWAIT: if (!rx_s) begin
                        state_q <= ST_MLOW;
                        mcnt_q  <= PER_W'(1);
                     end
                     ST_MLOW: if (rx_s) begin
                        if (mcnt_q < PER_W'(MIN_LOW)) state_q <= ST_MWAIT;
                        else begin
                           sel_q   <= pick_sel;
                           per_q   <= pick_per;
                           mcnt_q  <= '0;
                           state_q <= ST_SKIP;
                        end
                     end else if (mcnt_q != '1) mcnt_q <= mcnt_q + 1'b1;
                     ST_SKIP: if (mcnt_q == hold_last) state_q <= ST_CONF;
                     else mcnt_q <= mcnt_q + 1'b1;
                     ST_CONF: if (rx_done) begin
                        if (rx_byte == 8'h0D && rx_stop_ok) begin
                           state_q <= ST_GREET;
                           gi_q    <= '0;
                           tx_go_q <= 1'b1;
                        end else state_q <= ST_MWAIT;
                     end
                     default: ;
                  endcase
               end
            end
         endcase
      end
   end

   assign ring_o     = (state_q == ST_RING);
   assign me_o       = (state_q != ST_IDLE) && (state_q != ST_RING);
   assign cmd_mode_o = (state_q == ST_CMD);
   assign hangup_o   = hang_q;
   assign baud_sel_o = sel_q;

endmodule

// File: rtl/wab_seq_chk.sv
module wab_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic wake_i,
   input logic ring_o,
   input logic me_o,
   input logic cmd_mode_o,
   input logic hangup_o,
   input logic tx_o
);

   // R3
   ring_me_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ring_o && me_o));

   // R3
   wake_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ring_o && wake_i |=> me_o && !ring_o);

   // R1
   ring_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ring_o) |-> !$past(me_o));

   // R8
   hang_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hangup_o |-> !me_o && !cmd_mode_o && $past(me_o));

   // R8
   hang_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hangup_o |=> !hangup_o);

   // R9
   cmd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_mode_o && !wake_i |=> !me_o && !cmd_mode_o);

   // R7
   cmd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_mode_o) |-> tx_o && $past(me_o));

   // R10
   tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !me_o |-> tx_o);

endmodule

bind wake_autobaud_seq wab_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .ring_o(ring_o), .me_o(me_o),
   .cmd_mode_o(cmd_mode_o), .hangup_o(hangup_o), .tx_o(tx_o)
);

// File: tb/wake_autobaud_seq_bench.sv
module wake_autobaud_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 1228800;
   localparam int RING_CYC   = 2000;
   localparam int TO_CYC     = 30000;
   localparam int P300       = 4096;
   localparam int P1200      = 1024;
   localparam int P9600      = 128;
   localparam int P76800     = 16;

   logic       clk = 1'b0;
   logic       rst_n, rx, wake;
   logic       ring, me, cmd, hang, tx;
   logic [1:0] sel;

   int n_tests = 0;
   int n_fail  = 0;
   int n_hang  = 0;
   int cyc     = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wake_autobaud_seq #(
      .CLK_HZ(CLK_HZ), .RING_CYC(RING_CYC), .TIMEOUT_CYC(TO_CYC), .SYNC_STAGES(2)
   ) u_wake_autobaud_seq (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .wake_i(wake), .ring_o(ring), .me_o(me),
      .cmd_mode_o(cmd), .hangup_o(hang), .tx_o(tx), .baud_sel_o(sel)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-clock comparison against the model's invariants (R3, R10)
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (ring && me) begin
            n_fail++;
            $display("FAIL R3 ring/me actual=11 expected=not both");
         end
         if (!me && !tx) begin
            n_fail++;
            $display("FAIL R10 tx actual=0 expected=1");
         end
         if (hang) n_hang++;
      end
   end

   task automatic wait_until(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b, input int p);
      rx = 1'b0;
      repeat (p) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx = b[i];
         repeat (p) @(negedge clk);
      end
      rx = 1'b1;
      repeat (p) @(negedge clk);
   endtask

   task automatic get_byte(input int p, output logic [7:0] b, output logic ok);
      int w;
      w  = 0;
      ok = 1'b1;
      b  = '0;
      while (tx === 1'b1 && w < 40 * p) begin
         @(negedge clk);
         w++;
      end
      if (w >= 40 * p) begin
         ok = 1'b0;
         return;
      end
      repeat (p / 2) @(negedge clk);
      if (tx !== 1'b0) ok = 1'b0;
      for (int i = 0; i < 8; i++) begin
         repeat (p) @(negedge clk);
         b[i] = tx;
      end
      repeat (p) @(negedge clk);
      if (tx !== 1'b1) ok = 1'b0;
   endtask

   task automatic wake_up(output int w);
      send_byte(8'h0D, P76800);
      repeat (300) @(negedge clk);
      wake = 1'b1;
      @(negedge clk);
      w = cyc;
      check("R3 ring cleared on wake", {31'd0, ring}, 32'd0);
      check("R3 me set on wake", {31'd0, me}, 32'd1);
   endtask

   task automatic lock_and_greet(input int p, input logic [1:0] exp_sel, input string tag);
      logic [7:0] g0, g1, g2;
      logic       k0, k1, k2;
      send_byte(8'h0D, p);
      fork
         send_byte(8'h0D, p);
         begin
            get_byte(p, g0, k0);
            get_byte(p, g1, k1);
            get_byte(p, g2, k2);
         end
      join
      check({"R7 greet0 ", tag}, {23'd0, k0, g0}, {23'd0, 1'b1, 8'h0D});
      check({"R7 greet1 ", tag}, {23'd0, k1, g1}, {23'd0, 1'b1, 8'h0A});
      check({"R7 greet2 ", tag}, {23'd0, k2, g2}, {23'd0, 1'b1, 8'h2A});
      repeat (p) @(negedge clk);
      check({"R7 cmd mode ", tag}, {30'd0, cmd, me}, {30'd0, 2'b11});
      check({"R4 rate ", tag}, {30'd0, sel}, {30'd0, exp_sel});
      wake = 1'b0;
      @(negedge clk);
      check({"R9 release ", tag}, {30'd0, cmd, me}, 32'd0);
      repeat (20) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int w;
      rst_n = 1'b0;
      rx    = 1'b1;
      wake  = 1'b0;
      repeat (5) @(negedge clk);
      // R11 reset state
      check("R11 reset outputs", {26'd0, ring, me, cmd, hang, tx, 1'b0},
            {26'd0, 6'b000010});
      check("R11 reset rate", {30'd0, sel}, 32'd0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      // R1 / R2: ring latency and self-expiry
      fork
         send_byte(8'h0D, P76800);
         begin
            repeat (2) @(posedge clk);
            @(negedge clk);
            check("R1 ring not yet", {31'd0, ring}, 32'd0);
            @(posedge clk);
            @(negedge clk);
            check("R1 ring rises", {31'd0, ring}, 32'd1);
            repeat (RING_CYC - 1) @(posedge clk);
            @(negedge clk);
            check("R2 ring last cycle", {31'd0, ring}, 32'd1);
            @(posedge clk);
            @(negedge clk);
            check("R2 ring expired", {30'd0, ring, me}, 32'd0);
         end
      join
      repeat (50) @(negedge clk);

      // R6 / R8: wrong character restarts measurement, deadline keeps running
      wake_up(w);
      send_byte(8'h41, P9600);
      send_byte(8'h41, P9600);
      check("R4 rate from 'A' start bit", {30'd0, sel}, 32'd2);
      check("R6 no lock on non-CR", {31'd0, cmd}, 32'd0);
      wait_until(w + TO_CYC - 1);
      check("R6 R8 me held before deadline", {31'd0, me}, 32'd1);
      @(negedge clk);
      check("R8 hang-up at deadline", {30'd0, me, hang}, {30'd0, 2'b01});
      @(negedge clk);
      check("R8 hang-up pulse one cycle", {31'd0, hang}, 32'd0);
      wake = 1'b0;
      repeat (50) @(negedge clk);

      // R5 glitch, then lock at 9600
      wake_up(w);
      rx = 1'b0;
      repeat (3) @(negedge clk);
      rx = 1'b1;
      repeat (50) @(negedge clk);
      lock_and_greet(P9600, 2'd2, "R5 glitch then 9600");

      // R4 / R7 at the fastest and a slow rate
      wake_up(w);
      lock_and_greet(P76800, 2'd3, "76800");
      wake_up(w);
      lock_and_greet(P1200, 2'd1, "1200");

      check("R8 total hang-up pulses", n_hang, 32'd1);
      n_tests++; // per-clock R3/R10 comparison group
      if (P300 == 0) n_fail++;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule